// File: doc/BRIEF.md
# Packet Statistics Counter Bank with Ordered Read-to-Clear

This block counts transmitted and received packets and error packets for a physical-layer port, plus link-loss events, and exposes the counts on a small 16-bit register read port. The transmit and receive counters form two independent groups. Each group is three registers: the low half of a 32-bit packet count, the high half, and a 16-bit error count. A group is cleared only by reading its three registers in exactly that order. Reading the low half freezes the group, so the two halves and the error count are one coherent snapshot.

Events that arrive while a group is frozen are collected in a shadow accumulator. When the ordered read completes, the shadow value becomes the new live count. When the sequence is broken, the shadow is added back into the unchanged live count. No event is lost either way. All counters saturate at all-ones. The link-loss count is 6 bits wide. It is shown in the top bits of a link-quality register and clears when that register is read.

Software reads the link-quality register, then registers 1, 2 and 3, then 4, 5 and 6. It adds the snapshot to its own running totals.

Top module: `stat_bank`

## Requirements
- R1: After reset, rdata_o is zero and every register reads as zero.
- R2: A read with rd_en_i high loads rdata_o at the next clock edge with the addressed register. rdata_o holds its value when no read is issued. The address map is:
  - 0: link-quality register, with the loss count in bits 15:10 and the other bits zero.
  - 1: transmit packet count, low half.
  - 2: transmit packet count, high half.
  - 3: transmit error count.
  - 4: receive packet count, low half.
  - 5: receive packet count, high half.
  - 6: receive error count.
  - Any other address reads as zero.
- R3: While a group is not frozen, each cycle with its packet or error event input high adds one to that count.
- R4: A read of a group's first register (1 or 4) while the group is idle freezes the group. Its registers then return unchanged values until the sequence ends.
- R5: Reads of the first, second and third registers of a frozen group in consecutive read operations clear the group. Events received during the freeze, including any in the clearing cycle, become the new live counts.
- R6: Any other read while a group is frozen ends the freeze without clearing, and the events collected meanwhile are added to the live counts. This covers a repeated read, a skipped register, a read of the other group, the link register or an unmapped address. In particular, the order 1, 2, 1, 2, 3 does not clear the transmit group.
- R7: Reading a group's second or third register while the group is idle changes no count and starts no sequence.
- R8: Counters saturate at all-ones and never wrap: 32-bit packet counts, 16-bit error counts and the 6-bit loss count.
- R9: Reading the link-quality register clears the loss count. A loss event in the same cycle leaves the count at one.
- R10: Each 32-bit packet count is split across two registers: bits 15:0 in the low register and bits 31:16 in the high register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_pkt_i | input | 1 | One transmit packet counted this cycle |
| tx_err_i | input | 1 | One transmit error packet counted this cycle |
| rx_pkt_i | input | 1 | One receive packet counted this cycle |
| rx_err_i | input | 1 | One receive error packet counted this cycle |
| link_loss_i | input | 1 | One link-loss event this cycle |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| rdata_o | output | 16 | Registered read data, valid the cycle after rd_en_i |

## Verification
The bound checker checks the following on every cycle:
- rdata_o holds when no read is issued.
- Unmapped addresses and the unused low bits of the link register read as zero.
- A first-register read freezes the transmit group, and its live count stays still while frozen.
- The loss counter clears on read and sticks at its maximum.

Only the bench scenarios can show the following, because they depend on ordered histories of several reads:
- That the exact ordered read clears a group.
- That every kind of deviation cancels the clear.
- That shadowed events reappear in the live count after either outcome.
- That the 16-bit error count and the loss count saturate.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int NUM_GRP   = 2;
  localparam int GRP_REGS  = 3;
  localparam int LINK_ADDR = 0;
  localparam int GRP_BASE  = 1;
  localparam int LAST_ADDR = GRP_BASE + NUM_GRP * GRP_REGS - 1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT1 = 2'd1,
    SEQ_GOT2 = 2'd2
  } seq_e;
endpackage

// File: rtl/stat_sat_add.sv
module stat_sat_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] full;

  always_comb begin
    full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o = full[W] ? {W{1'b1}} : full[W-1:0];
  end
endmodule

// File: rtl/stat_cell.sv
// One counter with live value and freeze-time shadow accumulator.
module stat_cell #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ev_i,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic         abort_i,
  output logic [W-1:0] live_o
);
  logic [W-1:0] live_q, shadow_q;
  logic [W-1:0] add_a, add_b, sum;

  always_comb begin
    add_a = (clr_i || hold_i) ? shadow_q : live_q;
    add_b = abort_i ? shadow_q : '0;
  end

  stat_sat_add #(.W(W)) u_add (
    .a_i  (add_a),
    .b_i  (add_b),
    .cin_i(ev_i),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else if (clr_i || abort_i) begin
      live_q   <= sum;
      shadow_q <= '0;
    end else if (hold_i) begin
      shadow_q <= sum;
    end else begin
      live_q <= sum;
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/stat_group.sv
module stat_group
  import stat_bank_pkg::*;
#(
  parameter int PKT_W = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_ev_i,
  input  logic             err_ev_i,
  input  logic [2:0]       rd_hit_i,
  input  logic             rd_any_i,
  output logic [PKT_W-1:0] pkt_o,
  output logic [ERR_W-1:0] err_o,
  output logic             frozen_o
);
  seq_e st_q, st_d;
  logic start, clr, abort, hold;

  always_comb begin
    start = (st_q == SEQ_IDLE) && rd_hit_i[0];
    clr   = (st_q == SEQ_GOT2) && rd_hit_i[2];
    abort = rd_any_i && (((st_q == SEQ_GOT1) && !rd_hit_i[1]) ||
                         ((st_q == SEQ_GOT2) && !rd_hit_i[2]));
    hold  = start || ((st_q != SEQ_IDLE) && !clr && !abort);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (rd_hit_i[0]) st_d = SEQ_GOT1;
      SEQ_GOT1: if (rd_any_i) st_d = rd_hit_i[1] ? SEQ_GOT2 : SEQ_IDLE;
      SEQ_GOT2: if (rd_any_i) st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  stat_cell #(.W(PKT_W)) u_pkt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (pkt_ev_i),
    .hold_i (hold),
    .clr_i  (clr),
    .abort_i(abort),
    .live_o (pkt_o)
  );

  stat_cell #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (err_ev_i),
    .hold_i (hold),
    .clr_i  (clr),
    .abort_i(abort),
    .live_o (err_o)
  );

  assign frozen_o = (st_q != SEQ_IDLE);
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int PKT_W  = 32,
  parameter int ERR_W  = 16,
  parameter int LOSS_W = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_pkt_i,
  input  logic              tx_err_i,
  input  logic              rx_pkt_i,
  input  logic              rx_err_i,
  input  logic              link_loss_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_GRP-1:0] pkt_ev, err_ev, frozen_w;
  logic [PKT_W-1:0]   pkt_w [NUM_GRP];
  logic [ERR_W-1:0]   err_w [NUM_GRP];
  logic [LOSS_W-1:0]  loss_q, loss_sum;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               loss_rd;

  assign pkt_ev = {rx_pkt_i, tx_pkt_i};
  assign err_ev = {rx_err_i, tx_err_i};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int BASE = GRP_BASE + g * GRP_REGS;
    logic [2:0] hit;
    for (genvar k = 0; k < GRP_REGS; k++) begin : g_hit
      assign hit[k] = rd_en_i && (addr_i == ADDR_W'(BASE + k));
    end
    stat_group #(.PKT_W(PKT_W), .ERR_W(ERR_W)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pkt_ev_i(pkt_ev[g]),
      .err_ev_i(err_ev[g]),
      .rd_hit_i(hit),
      .rd_any_i(rd_en_i),
      .pkt_o   (pkt_w[g]),
      .err_o   (err_w[g]),
      .frozen_o(frozen_w[g])
    );
  end

  // link-loss counter, clear on read
  assign loss_rd = rd_en_i && (addr_i == ADDR_W'(LINK_ADDR));

  stat_sat_add #(.W(LOSS_W)) u_loss_add (
    .a_i  (loss_q),
    .b_i  ('0),
    .cin_i(link_loss_i),
    .sum_o(loss_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      loss_q <= '0;
    else if (loss_rd) loss_q <= LOSS_W'(link_loss_i);
    else              loss_q <= loss_sum;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(LINK_ADDR)) rd_mux[DATA_W-1 -: LOSS_W] = loss_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_i == ADDR_W'(GRP_BASE + g * GRP_REGS))
        rd_mux = pkt_w[g][DATA_W-1:0];
      if (addr_i == ADDR_W'(GRP_BASE + g * GRP_REGS + 1))
        rd_mux = pkt_w[g][2*DATA_W-1:DATA_W];
      if (addr_i == ADDR_W'(GRP_BASE + g * GRP_REGS + 2))
        rd_mux = DATA_W'(err_w[g]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
  import stat_bank_pkg::*;
#(
  parameter int PKT_W  = 32,
  parameter int LOSS_W = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               link_loss_i,
  input logic [NUM_GRP-1:0] frozen_i,
  input logic [PKT_W-1:0]   tx_pkt_q_i,
  input logic [LOSS_W-1:0]  loss_i
);
  localparam int TX_FIRST = GRP_BASE;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (int'(addr_i) > LAST_ADDR)) |=> (rdata_o == '0)); // R2

  AST_LINK_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_W'(LINK_ADDR))) |=> (rdata_o[DATA_W-LOSS_W-1:0] == '0)); // R9

  AST_FREEZE_ON_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_W'(TX_FIRST)) && !frozen_i[0]) |=> frozen_i[0]); // R4

  AST_FROZEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i[0] && $past(frozen_i[0])) |-> $stable(tx_pkt_q_i)); // R4

  AST_LOSS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == ADDR_W'(LINK_ADDR)) && !link_loss_i) |=> (loss_i == '0)); // R9

  AST_LOSS_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((loss_i == '1) && !(rd_en_i && (addr_i == ADDR_W'(LINK_ADDR)))) |=> (loss_i == '1)); // R8
endmodule

bind stat_bank stat_bank_chk #(
  .PKT_W (PKT_W),
  .LOSS_W(LOSS_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .link_loss_i(link_loss_i),
  .frozen_i   (frozen_w),
  .tx_pkt_q_i (pkt_w[0]),
  .loss_i     (loss_q)
);

// File: tb/stat_bank_test.sv
module stat_bank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_pkt, tx_err, rx_pkt, rx_err, link_loss, rd_en;
  logic [3:0]  addr;
  logic [15:0] rdata;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  stat_bank uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tx_pkt_i   (tx_pkt),
    .tx_err_i   (tx_err),
    .rx_pkt_i   (rx_pkt),
    .rx_err_i   (rx_err),
    .link_loss_i(link_loss),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .rdata_o    (rdata)
  );

  // {req[3:0], rd, addr[3:0], ev[4:0] = {link,rx_err,rx_pkt,tx_err,tx_pkt}, exp[15:0]}
  localparam int NV = 47;
  localparam logic [29:0] VEC [NV] = '{
    {4'd1, 1'b1, 4'd0, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd1, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd3, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd4, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd5, 5'b00000, 16'h0000}, // R1
    {4'd1, 1'b1, 4'd6, 5'b00000, 16'h0000}, // R1
    {4'd3, 1'b0, 4'd0, 5'b00011, 16'h0000}, // R3
    {4'd3, 1'b0, 4'd0, 5'b00001, 16'h0000}, // R3
    {4'd3, 1'b0, 4'd0, 5'b00001, 16'h0000}, // R3
    {4'd4, 1'b1, 4'd1, 5'b00001, 16'h0003}, // R4 freeze, event shadowed
    {4'd4, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R4
    {4'd5, 1'b1, 4'd3, 5'b00001, 16'h0001}, // R5 clear
    {4'd7, 1'b1, 4'd3, 5'b00000, 16'h0000}, // R7 idle read of third
    {4'd5, 1'b1, 4'd1, 5'b00000, 16'h0002}, // R5 shadow carried
    {4'd6, 1'b1, 4'd1, 5'b00000, 16'h0002}, // R6 repeated first
    {4'd6, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R6
    {4'd6, 1'b1, 4'd3, 5'b00000, 16'h0000}, // R6 no clear
    {4'd6, 1'b1, 4'd1, 5'b00000, 16'h0002}, // R6 still 2
    {4'd5, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R5
    {4'd5, 1'b1, 4'd3, 5'b00000, 16'h0000}, // R5
    {4'd5, 1'b1, 4'd1, 5'b00000, 16'h0000}, // R5 cleared
    {4'd5, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R5
    {4'd5, 1'b1, 4'd3, 5'b00000, 16'h0000}, // R5
    {4'd3, 1'b0, 4'd0, 5'b01100, 16'h0000}, // R3
    {4'd3, 1'b0, 4'd0, 5'b00100, 16'h0000}, // R3
    {4'd3, 1'b1, 4'd4, 5'b00000, 16'h0002}, // R3 rx count
    {4'd6, 1'b1, 4'd0, 5'b00000, 16'h0000}, // R6 link read aborts rx
    {4'd7, 1'b1, 4'd5, 5'b00000, 16'h0000}, // R7
    {4'd7, 1'b1, 4'd6, 5'b00000, 16'h0001}, // R7 err kept
    {4'd5, 1'b1, 4'd4, 5'b00000, 16'h0002}, // R5
    {4'd5, 1'b1, 4'd5, 5'b00000, 16'h0000}, // R5
    {4'd5, 1'b1, 4'd6, 5'b00000, 16'h0001}, // R5
    {4'd5, 1'b1, 4'd4, 5'b00000, 16'h0000}, // R5 rx cleared
    {4'd5, 1'b1, 4'd5, 5'b00000, 16'h0000}, // R5
    {4'd5, 1'b1, 4'd6, 5'b00000, 16'h0000}, // R5
    {4'd9, 1'b0, 4'd0, 5'b10000, 16'h0000}, // R9
    {4'd9, 1'b0, 4'd0, 5'b10000, 16'h0000}, // R9
    {4'd9, 1'b1, 4'd0, 5'b10000, 16'h0800}, // R9 read with event
    {4'd9, 1'b1, 4'd0, 5'b00000, 16'h0400}, // R9 left at one
    {4'd6, 1'b1, 4'd1, 5'b00011, 16'h0000}, // R6 freeze tx
    {4'd6, 1'b1, 4'd4, 5'b00001, 16'h0000}, // R6 other group aborts tx
    {4'd6, 1'b1, 4'd1, 5'b00000, 16'h0002}, // R6 shadow merged
    {4'd6, 1'b1, 4'd2, 5'b00000, 16'h0000}, // R6
    {4'd6, 1'b1, 4'd3, 5'b00000, 16'h0001}, // R6 err merged
    {4'd2, 1'b1, 4'd1, 5'b00000, 16'h0000}, // R2
    {4'd2, 1'b1, 4'd7, 5'b00000, 16'h0000}  // R2 unmapped
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: rdata=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {link_loss, rx_err, rx_pkt, tx_err, tx_pkt} = '0;
    rd_en = 1'b0;
    addr  = '0;
  endtask

  task automatic do_read(input logic [3:0] a, input int req, input logic [15:0] exp);
    @(negedge clk);
    idle_inputs();
    rd_en = 1'b1;
    addr  = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end");
      finish_run();
    end
  end

  initial begin
    bit          pend;
    int          pend_req;
    logic [15:0] pend_exp;
    idle_inputs();
    repeat (3) @(negedge clk);
    check(1, rdata, 16'h0000); // R1 reset value
    rst_ni = 1'b1;
    pend = 1'b0;
    pend_req = 0;
    pend_exp = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (pend) check(pend_req, rdata, pend_exp);
      {link_loss, rx_err, rx_pkt, tx_err, tx_pkt} = VEC[i][20:16];
      rd_en    = VEC[i][25];
      addr     = VEC[i][24:21];
      pend     = VEC[i][25];
      pend_req = int'(VEC[i][29:26]);
      pend_exp = VEC[i][15:0];
    end
    @(negedge clk);
    if (pend) check(pend_req, rdata, pend_exp);
    idle_inputs();

    // R2: rdata holds without a read
    tx_pkt = 1'b1;
    repeat (3) @(negedge clk);
    tx_pkt = 1'b0;
    check(2, rdata, 16'h0000);

    // R10 and R8: long run, 70003 packets, error count saturates
    @(negedge clk);
    tx_pkt = 1'b1; tx_err = 1'b1; link_loss = 1'b1;
    repeat (70000) @(negedge clk);
    idle_inputs();
    do_read(4'd1, 10, 16'h1173); // R10 low half of 70003
    do_read(4'd2, 10, 16'h0001); // R10 high half
    do_read(4'd3, 8, 16'hFFFF);  // R8 error saturated
    do_read(4'd0, 8, 16'hFC00);  // R8 loss saturated at 63
    do_read(4'd0, 9, 16'h0000);  // R9 cleared

    // R1: reset mid-run
    tx_pkt = 1'b1;
    repeat (5) @(negedge clk);
    tx_pkt = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    check(1, rdata, 16'h0000);
    rst_ni = 1'b1;
    do_read(4'd1, 1, 16'h0000);
    finish_run();
  end
endmodule